// File: doc/BRIEF.md
# Four-Port GPIO Register Bank

This block holds the control state for four 8-bit general-purpose I/O ports behind a simple single-cycle register bus. Software reaches it through an 8-bit address, separate read and write strobes, an 8-bit data path and a two-bit access-size qualifier. Each port has an output data register, an output mode register, a direction register and a read-only pin register. Two extra select registers carry pin-function choices for neighbouring logic. Registers sit in a sparse, grouped address map. Each register has its own mask of implemented bits.

An illegal access leaves every register unchanged and raises the error response. Illegal accesses are: an unmapped offset, a size other than one byte, a write to a pin register, or a write that sets a bit the target does not implement. The pad side is modelled as three 32-bit vectors. Port p uses bits [8p+7:8p] of each vector. The output value comes from the output data registers and the output enable comes from the direction registers. The pad input vector passes through a two-flop synchronizer before the pin registers can read it.

The bus response is registered. For an access presented at a clock edge, `bus_err` and `bus_rdata` are valid during the following cycle. A write takes effect at the same edge that samples it.

Top module: `gpio_quad_regs`

## Requirements
- R1: After reset, every output, direction and pin register and the port 0, 1 and 3 mode registers read 0x00. The port 2 mode register reads 0xFF, the port 2 select register reads 0x00 and the port 4 select register reads 0x0F.
- R2: The output registers of ports 0 to 3 sit at offsets 0x00, 0x01, 0x04 and 0x05. The mode registers sit at 0x20, 0x21, 0x24 and 0x25, and the direction registers at 0x60, 0x61, 0x64 and 0x65. A legal byte write to any of these is returned by a later byte read of the same offset.
- R3: An access to any offset outside the map sets `bus_err`, returns 0x00 on `bus_rdata` and changes no register.
- R4: `bus_size` encodes 0 as byte, 1 as halfword and 2 or 3 as word. Any non-byte read or write sets `bus_err`, returns 0x00 and changes no register.
- R5: Port 3 implements only bits [1:0] of its output, mode and direction registers. A write to one of them that sets any of bits [7:2] is rejected with `bus_err` and the register keeps its old value.
- R6: The mode registers of ports 0 and 1 implement only bit 0. A write to either that sets any of bits [7:1] is rejected with `bus_err` and no change.
- R7: The select registers sit at 0x44, implementing bits [1:0], and at 0x48, implementing bits [3:0]. A write setting a higher bit is rejected with `bus_err` and no change.
- R8: The pin registers at 0x80, 0x81, 0x84 and 0x85 are read-only. A write to one of them sets `bus_err` and changes nothing.
- R9: A pin register read returns the matching byte of `pad_in` delayed by two synchronizer flops. A change of `pad_in` is not seen by a read that completes within two edges of the change, and is seen once the input has been stable for three edges.
- R10: `pad_out` equals the four output registers and `pad_oe` equals the four direction registers, with port p in bits [8p+7:8p]. A direction bit of 1 enables the output.
- R11: `bus_err` and `bus_rdata` are registered one cycle after the access edge. In a cycle that follows an edge with no access, both are 0.
- R12: `fsel_p2` shows select register 0x44 bits [1:0] and `fsel_p4` shows select register 0x48 bits [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset from the block base |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_rdata | output | 8 | Read data, valid the cycle after the access |
| bus_err | output | 1 | Error response, valid the cycle after the access |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 means drive |
| fsel_p2 | output | 2 | Port 2 pin-function select |
| fsel_p4 | output | 4 | Port 4 pin-function select |

## Verification
The bench targets the per-register masks: port 3 with bit 2 set, the port 0 and 1 mode registers with bit 1 set, and each select register one bit above its width. A design with a shared mask would accept these writes, corrupt state and stay silent. Holes in the sparse map, such as 0x02, 0x22 and 0x40, must raise an error. A decoder that looks at too few address bits would alias them onto real registers. Non-byte sizes and pin-register writes are checked for both the error flag and unchanged readback, which catches a design that flags the error but still writes. A read issued just after `pad_in` changes must still return the old value, which exposes a synchronizer that is missing or only one flop deep.

// File: rtl/gpio_quad_pkg.sv
package gpio_quad_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned NPORTS = 4;
    localparam int unsigned PIN_W  = NPORTS * DATA_W;
    localparam int unsigned PIDX_W = $clog2(NPORTS);

    localparam logic [1:0] SZ_BYTE = 2'b00;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_OUT  = 3'd1,
        K_MODE = 3'd2,
        K_DIR  = 3'd3,
        K_PIN  = 3'd4,
        K_SEL2 = 3'd5,
        K_SEL4 = 3'd6
    } reg_kind_e;

    // Implemented bits for a register, by kind and port.
    function automatic logic [DATA_W-1:0] impl_mask(reg_kind_e k, logic [PIDX_W-1:0] p);
        logic [DATA_W-1:0] m;
        m = '1;
        unique case (k)
            K_OUT, K_DIR: m = (p == PIDX_W'(3)) ? DATA_W'(8'h03) : '1;
            K_MODE: begin
                if (p == PIDX_W'(3))
                    m = DATA_W'(8'h03);
                else if (p == PIDX_W'(0) || p == PIDX_W'(1))
                    m = DATA_W'(8'h01);
                else
                    m = '1;
            end
            K_SEL2: m = DATA_W'(8'h03);
            K_SEL4: m = DATA_W'(8'h0F);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_quad_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [PIDX_W-1:0] port
);

    logic       port_slot;
    logic [2:0] grp;

    // Port-indexed groups use offsets {0,1,4,5} inside a 32-byte group.
    assign grp       = addr[7:5];
    assign port_slot = (addr[4:3] == 2'b00) && (addr[1] == 1'b0);

    always_comb begin
        kind = K_NONE;
        port = {addr[2], addr[0]};
        unique case (grp)
            3'd0: kind = port_slot ? K_OUT  : K_NONE;
            3'd1: kind = port_slot ? K_MODE : K_NONE;
            3'd2: begin
                if (addr == ADDR_W'(8'h44))
                    kind = K_SEL2;
                else if (addr == ADDR_W'(8'h48))
                    kind = K_SEL4;
                else
                    kind = K_NONE;
            end
            3'd3: kind = port_slot ? K_DIR  : K_NONE;
            3'd4: kind = port_slot ? K_PIN  : K_NONE;
            default: kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = d;
        s_d.sync = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign q = s_q.sync;

endmodule

// File: rtl/gpio_quad_regs.sv
module gpio_quad_regs
    import gpio_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [1:0]        fsel_p2,
    output logic [3:0]        fsel_p4
);

    localparam logic [DATA_W-1:0] MODE2_RST = '1;
    localparam logic [DATA_W-1:0] SEL4_RST  = DATA_W'(8'h0F);

    typedef struct packed {
        logic [NPORTS-1:0][DATA_W-1:0] outr;
        logic [NPORTS-1:0][DATA_W-1:0] mode;
        logic [NPORTS-1:0][DATA_W-1:0] dir;
        logic [DATA_W-1:0]             sel2;
        logic [DATA_W-1:0]             sel4;
        logic [DATA_W-1:0]             rdata;
        logic                          err;
    } state_t;

    state_t st_d, st_q;

    reg_kind_e                     dec_kind;
    logic [PIDX_W-1:0]             dec_port;
    logic [PIN_W-1:0]              pin_sync;
    logic [NPORTS-1:0][DATA_W-1:0] pin_bytes;

    gpio_addr_decode u_dec (
        .addr (bus_addr),
        .kind (dec_kind),
        .port (dec_port)
    );

    gpio_sync2 #(.W(PIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_pin
        assign pin_bytes[p] = pin_sync[p*DATA_W +: DATA_W];
    end

    logic              acc;
    logic              hdr_bad;
    logic              wr_bad;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        acc     = bus_wr | bus_rd;
        hdr_bad = (dec_kind == K_NONE) || (bus_size != SZ_BYTE);
        mask    = impl_mask(dec_kind, dec_port);
        wr_bad  = hdr_bad || (dec_kind == K_PIN) || ((bus_wdata & ~mask) != '0);

        unique case (dec_kind)
            K_OUT:   rd_mux = st_q.outr[dec_port];
            K_MODE:  rd_mux = st_q.mode[dec_port];
            K_DIR:   rd_mux = st_q.dir[dec_port];
            K_PIN:   rd_mux = pin_bytes[dec_port];
            K_SEL2:  rd_mux = st_q.sel2;
            K_SEL4:  rd_mux = st_q.sel4;
            default: rd_mux = '0;
        endcase

        st_d       = st_q;
        st_d.err   = 1'b0;
        st_d.rdata = '0;

        if (acc) begin
            if (bus_wr) begin
                if (wr_bad) begin
                    st_d.err = 1'b1;
                end else begin
                    unique case (dec_kind)
                        K_OUT:   st_d.outr[dec_port] = bus_wdata;
                        K_MODE:  st_d.mode[dec_port] = bus_wdata;
                        K_DIR:   st_d.dir[dec_port]  = bus_wdata;
                        K_SEL2:  st_d.sel2           = bus_wdata;
                        K_SEL4:  st_d.sel4           = bus_wdata;
                        default: st_d.err            = 1'b1;
                    endcase
                end
            end else begin
                if (hdr_bad)
                    st_d.err = 1'b1;
                else
                    st_d.rdata = rd_mux;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.mode[2] <= MODE2_RST;
            st_q.sel4    <= SEL4_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;
    assign pad_out   = st_q.outr;
    assign pad_oe    = st_q.dir;
    assign fsel_p2   = st_q.sel2[1:0];
    assign fsel_p4   = st_q.sel4[3:0];

    // R4
    size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_size != SZ_BYTE) |=> bus_err);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!bus_err && bus_rdata == '0));

    // R3
    unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec_kind == K_NONE) |=> (bus_err && bus_rdata == '0));

    // R8
    pin_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec_kind == K_PIN) |=> (bus_err && $stable(pad_out) && $stable(pad_oe)));

    // R5
    p3_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out[PIN_W-1:PIN_W-6] == 6'd0 && pad_oe[PIN_W-1:PIN_W-6] == 6'd0));

    // R7
    sel_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec_kind == K_SEL4 && bus_wdata[7:4] != 4'd0) |=> (bus_err && $stable(fsel_p4)));

endmodule

// File: tb/gpio_quad_regs_bench.sv
`timescale 1ns/1ps
module gpio_quad_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [1:0]  bus_size = '0;
    logic [7:0]  bus_rdata;
    logic        bus_err;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [1:0]  fsel_p2;
    logic [3:0]  fsel_p4;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] model [0:255];

    always #5 clk = ~clk;

    gpio_quad_regs u_gpio_quad_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_size(bus_size),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fsel_p2(fsel_p2), .fsel_p4(fsel_p4)
    );

    // 0 unmapped, 1 read/write, 2 pin (read-only)
    function automatic int kind_of(logic [7:0] a);
        logic slot;
        slot = (a[4:3] == 2'b00) && (a[1] == 1'b0);
        if (a == 8'h44 || a == 8'h48) return 1;
        if (!slot) return 0;
        case (a[7:5])
            3'd0, 3'd1, 3'd3: return 1;
            3'd4: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] mask_of(logic [7:0] a);
        if (a == 8'h44) return 8'h03;
        if (a == 8'h48) return 8'h0F;
        if (a == 8'h05 || a == 8'h25 || a == 8'h65) return 8'h03;
        if (a == 8'h20 || a == 8'h21) return 8'h01;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] legal_addr(int i);
        logic [7:0] base;
        if (i == 16) return 8'h44;
        if (i == 17) return 8'h48;
        case (i / 4)
            0: base = 8'h00;
            1: base = 8'h20;
            2: base = 8'h60;
            default: base = 8'h80;
        endcase
        return base + (((i % 4) >= 2) ? 8'd4 : 8'd0) + 8'(i % 2);
    endfunction

    function automatic logic [7:0] pin_byte(logic [7:0] a, logic [31:0] pins);
        int p;
        p = {a[2], a[0]};
        return pins[p*8 +: 8];
    endfunction

    function automatic string req_of(logic [7:0] a, logic w, logic [7:0] d, logic [1:0] sz);
        if (sz != 2'b00) return "R4";
        if (kind_of(a) == 0) return "R3";
        if (w && kind_of(a) == 2) return "R8";
        if (w && (d & ~mask_of(a)) != 0) begin
            if (a == 8'h44 || a == 8'h48) return "R7";
            if (a == 8'h20 || a == 8'h21) return "R6";
            return "R5";
        end
        if (kind_of(a) == 2) return "R9";
        return "R2";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [7:0] a, input logic w, input logic [7:0] d,
                       input logic [1:0] sz, output logic [7:0] rd, output logic e);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = !w; bus_wdata = d; bus_size = sz;
        @(posedge clk);
        #1;
        rd = bus_rdata;
        e  = bus_err;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    // Access with model update and full checking of the response.
    task automatic op(input logic [7:0] a, input logic w, input logic [7:0] d,
                      input logic [1:0] sz, input string req);
        logic [7:0] rd;
        logic       e, exp_e;
        logic [7:0] exp_rd;
        acc(a, w, d, sz, rd, e);
        if (w) begin
            exp_e = (sz != 2'b00) || (kind_of(a) != 1) || ((d & ~mask_of(a)) != 0);
            if (!exp_e) model[a] = d;
            exp_rd = 8'h00;
        end else begin
            exp_e  = (sz != 2'b00) || (kind_of(a) == 0);
            exp_rd = exp_e ? 8'h00 : (kind_of(a) == 2 ? pin_byte(a, pad_in) : model[a]);
        end
        chk({req, " err"}, {31'd0, e}, {31'd0, exp_e});
        chk({req, " rdata"}, {24'd0, rd}, {24'd0, exp_rd});
    endtask

    task automatic check_pads(string req);
        logic [31:0] eo, ee;
        for (int p = 0; p < 4; p++) begin
            eo[p*8 +: 8] = model[legal_addr(p)];
            ee[p*8 +: 8] = model[legal_addr(8 + p)];
        end
        chk({req, " pad_out"}, pad_out, eo);
        chk({req, " pad_oe"}, pad_oe, ee);
        chk({req, " fsel_p2"}, {30'd0, fsel_p2}, {30'd0, model[8'h44][1:0]});
        chk({req, " fsel_p4"}, {28'd0, fsel_p4}, {28'd0, model[8'h48][3:0]});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       e;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        model[8'h24] = 8'hFF;
        model[8'h48] = 8'h0F;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 reset values, R11 idle response
        #1;
        chk("R11 idle err", {31'd0, bus_err}, 32'd0);
        chk("R11 idle rdata", {24'd0, bus_rdata}, 32'd0);
        check_pads("R1");
        for (int i = 0; i < 18; i++) op(legal_addr(i), 1'b0, 8'h00, 2'b00, "R1");

        // R2 legal writes and readback
        for (int i = 0; i < 16; i++) begin
            if (i < 12 || i >= 16) op(legal_addr(i), 1'b1, 8'hA5 & mask_of(legal_addr(i)), 2'b00, "R2");
        end
        for (int i = 0; i < 12; i++) op(legal_addr(i), 1'b0, 8'h00, 2'b00, "R2");
        check_pads("R10");

        // R3 holes in the map
        op(8'h02, 1'b0, 8'h00, 2'b00, "R3");
        op(8'h22, 1'b1, 8'h01, 2'b00, "R3");
        op(8'h40, 1'b1, 8'h01, 2'b00, "R3");
        op(8'hFF, 1'b0, 8'h00, 2'b00, "R3");
        op(8'h08, 1'b1, 8'h33, 2'b00, "R3");
        op(8'h00, 1'b0, 8'h00, 2'b00, "R3");

        // R4 non-byte sizes
        op(8'h00, 1'b1, 8'h5A, 2'b01, "R4");
        op(8'h60, 1'b1, 8'h5A, 2'b10, "R4");
        op(8'h00, 1'b0, 8'h00, 2'b11, "R4");
        op(8'h00, 1'b0, 8'h00, 2'b00, "R4");
        op(8'h60, 1'b0, 8'h00, 2'b00, "R4");

        // R5 port 3 reserved bits
        op(8'h05, 1'b1, 8'h04, 2'b00, "R5");
        op(8'h65, 1'b1, 8'h80, 2'b00, "R5");
        op(8'h25, 1'b1, 8'h03, 2'b00, "R5");
        op(8'h05, 1'b0, 8'h00, 2'b00, "R5");
        op(8'h25, 1'b0, 8'h00, 2'b00, "R5");

        // R6 port 0/1 mode reserved bits
        op(8'h20, 1'b1, 8'h02, 2'b00, "R6");
        op(8'h21, 1'b1, 8'h81, 2'b00, "R6");
        op(8'h21, 1'b1, 8'h01, 2'b00, "R6");
        op(8'h20, 1'b0, 8'h00, 2'b00, "R6");
        op(8'h21, 1'b0, 8'h00, 2'b00, "R6");

        // R7 / R12 select registers
        op(8'h44, 1'b1, 8'h04, 2'b00, "R7");
        op(8'h48, 1'b1, 8'h10, 2'b00, "R7");
        op(8'h44, 1'b1, 8'h02, 2'b00, "R7");
        op(8'h48, 1'b1, 8'h0A, 2'b00, "R7");
        op(8'h48, 1'b0, 8'h00, 2'b00, "R7");
        check_pads("R12");

        // R8 pin registers read-only
        op(8'h84, 1'b1, 8'h11, 2'b00, "R8");
        op(8'h80, 1'b1, 8'h00, 2'b00, "R8");
        check_pads("R8");

        // R9 synchronizer delay
        @(negedge clk);
        pad_in = 32'hC3_5A_96_E1;
        bus_addr = 8'h81; bus_rd = 1'b1; bus_wr = 1'b0; bus_size = 2'b00;
        @(posedge clk);
        #1 chk("R9 first read old", {24'd0, bus_rdata}, 32'd0);
        @(posedge clk);
        #1 chk("R9 second read old", {24'd0, bus_rdata}, 32'd0);
        bus_rd = 1'b0;
        repeat (3) @(posedge clk);
        for (int i = 12; i < 16; i++) op(legal_addr(i), 1'b0, 8'h00, 2'b00, "R9");

        // Random mix
        for (int n = 0; n < 800; n++) begin
            logic [7:0] a, d;
            logic       w;
            logic [1:0] sz;
            int         r;
            r  = int'($urandom_range(0, 99));
            a  = (r < 70) ? legal_addr(int'($urandom_range(0, 17))) : 8'($urandom);
            d  = 8'($urandom);
            if ($urandom_range(0, 1) == 1) d = d & mask_of(a);
            w  = 1'($urandom);
            sz = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            op(a, w, d, sz, req_of(a, w, d, sz));
        end
        #1 check_pads("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule